// File: doc/BRIEF.md
# Segmented Row-Register DRAM Cache

This block is a synthesizable behavioural model of a DRAM whose storage is split into four segments, each fronted by a single whole-row cache register. Each register is paired with a tag latch that records which row it currently holds. Every read is answered from the row register of the addressed segment. A comparator checks the requested row against that segment's tag. On a match the word comes back on the next cycle and an active-low hit flag goes low. On a mismatch the complete row is copied from the array into the register in one wide transfer. The tag is updated, and the word is delivered after a fixed reload delay with the hit flag high.

Writes land in a one-entry posting register and are committed to the array on the following cycle. A write whose row matches the cached row of its segment also patches the row register in the same cycle, so cached data never goes stale. A refresh counter advances one row per granted refresh request. Refresh is held off while a reload is running and never touches the row registers.

The request port accepts one read or write per cycle whenever `ready` is high. Requests presented while `ready` is low are dropped.

Top module: `rrc_top`

## Requirements
- R1: After reset `ready` is high, `rd_valid` and `refresh_gnt` are low, `hit_n` is high, and every tag is invalid, so the first read to each segment misses.
- R2: The address is split as {segment, row, column}: segment in the top SEG_BITS bits, column in the low COL_BITS bits, row between them. Each of the four segments keeps its own row register and tag, and a reload in one segment leaves the others cached.
- R3: A read accepted while its row matches the segment tag returns the word with `rd_valid` high and `hit_n` low on the cycle after acceptance, and `ready` stays high.
- R4: A read that misses drops `ready` for exactly MISS_LAT cycles. On the cycle after that window, `rd_valid` is high with `hit_n` high and the word from the freshly loaded row, and the tag now holds that row.
- R5: Further reads to the cached row, in any column order, hit back to back at one per cycle with no further reload.
- R6: A write is accepted in one cycle. Any later read returns the written value, including a read that reloads the row on the very next cycle.
- R7: A write whose row matches the segment tag updates the row register, so the next hit returns the new value.
- R8: A write whose row does not match the tag leaves the row register and tag unchanged: a later read of the cached row still hits with its old contents.
- R9: Each refresh grant is a one-cycle pulse on `refresh_gnt`, and `refresh_row` advances by one, wrapping modulo the rows per segment.
- R10: A refresh request is granted only on a cycle where `ready` is high and no reload starts. Otherwise it stays pending and is granted on the first cycle that allows it.
- R11: Refresh does not change any row register: a hit after a refresh returns the same data as before it.
- R12: A request presented while `ready` is low is ignored and changes neither the array nor any row register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | SEG_BITS+ROW_BITS+COL_BITS | Word address {segment, row, column} |
| req_wdata | input | DATA_W | Write data |
| ready | output | 1 | High when a request can be accepted |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DATA_W | Read data, valid with rd_valid |
| hit_n | output | 1 | Low when the last read hit, high when it missed |
| refresh_req | input | 1 | Refresh request pulse |
| refresh_gnt | output | 1 | One-cycle refresh grant |
| refresh_row | output | ROW_BITS | Row index refreshed at the latest grant |

## Verification
The assertions assume that requests and refresh pulses are sampled only at rising edges and that MISS_LAT is at least one. They also assume the requester drops nothing it cares about while `ready` is low. The bench drives every input on the falling edge, so nothing changes near a sampling edge. It deliberately presents some requests while `ready` is low, because R12 defines those as discarded. The whole array is written before any read, so every row a reload copies holds known data.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
    typedef enum logic {
        ST_READY  = 1'b0,
        ST_RELOAD = 1'b1
    } rrc_state_e;
endpackage

// File: rtl/rrc_dram_array.sv
module rrc_dram_array #(
    parameter int DATA_W   = 8,
    parameter int SEG_BITS = 2,
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 2
) (
    input  logic                               clk,
    input  logic                               wr_en,
    input  logic [SEG_BITS-1:0]                wr_seg,
    input  logic [ROW_BITS-1:0]                wr_row,
    input  logic [COL_BITS-1:0]                wr_col,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic [SEG_BITS-1:0]                rd_seg,
    input  logic [ROW_BITS-1:0]                rd_row,
    output logic [DATA_W*(1<<COL_BITS)-1:0]    rd_line
);
    localparam int LINE_W = DATA_W * (1 << COL_BITS);
    localparam int NLINES = 1 << (SEG_BITS + ROW_BITS);

    logic [LINE_W-1:0] mem_q [NLINES];

    // Storage has no reset; the whole row is read combinationally for a wide reload.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{wr_seg, wr_row}][wr_col*DATA_W +: DATA_W] <= wr_data;
        end
    end

    assign rd_line = mem_q[{rd_seg, rd_row}];
endmodule

// File: rtl/rrc_seg_cache.sv
module rrc_seg_cache #(
    parameter int DATA_W   = 8,
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               load_en,
    input  logic [ROW_BITS-1:0]                load_row,
    input  logic [DATA_W*(1<<COL_BITS)-1:0]    load_line,
    input  logic                               wr_en,
    input  logic [COL_BITS-1:0]                wr_col,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic [ROW_BITS-1:0]                lookup_row,
    output logic                               hit,
    input  logic [COL_BITS-1:0]                rd_col,
    output logic [DATA_W-1:0]                  rd_data
);
    localparam int LINE_W = DATA_W * (1 << COL_BITS);

    typedef struct packed {
        logic                valid;
        logic [ROW_BITS-1:0] tag;
        logic [LINE_W-1:0]   line;
    } seg_t;

    seg_t state_d, state_q;

    assign hit     = state_q.valid && (state_q.tag == lookup_row);
    assign rd_data = state_q.line[rd_col*DATA_W +: DATA_W];

    always_comb begin
        state_d = state_q;
        if (load_en) begin
            state_d.valid = 1'b1;
            state_d.tag   = load_row;
            state_d.line  = load_line;
        end else if (wr_en && hit) begin
            state_d.line[wr_col*DATA_W +: DATA_W] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R4
    load_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (state_q.valid && state_q.tag == $past(load_row)));

    // R8
    wmiss_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit && !load_en) |=> $stable(state_q));
endmodule

// File: rtl/rrc_top.sv
module rrc_top #(
    parameter int DATA_W   = 8,
    parameter int SEG_BITS = 2,
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 2,
    parameter int MISS_LAT = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid,
    input  logic                                   req_write,
    input  logic [SEG_BITS+ROW_BITS+COL_BITS-1:0]  req_addr,
    input  logic [DATA_W-1:0]                      req_wdata,
    output logic                                   ready,
    output logic                                   rd_valid,
    output logic [DATA_W-1:0]                      rd_data,
    output logic                                   hit_n,
    input  logic                                   refresh_req,
    output logic                                   refresh_gnt,
    output logic [ROW_BITS-1:0]                    refresh_row
);
    import rrc_pkg::*;

    localparam int NSEG   = 1 << SEG_BITS;
    localparam int LINE_W = DATA_W * (1 << COL_BITS);
    localparam int ADDR_W = SEG_BITS + ROW_BITS + COL_BITS;
    localparam int CNT_W  = (MISS_LAT < 2) ? 1 : $clog2(MISS_LAT + 1);

    typedef struct packed {
        rrc_state_e          state;
        logic [CNT_W-1:0]    cnt;
        logic [COL_BITS-1:0] pend_col;
        logic [SEG_BITS-1:0] pend_seg;
        logic                rd_valid;
        logic [DATA_W-1:0]   rd_data;
        logic                hit_n;
        logic                post_valid;
        logic [SEG_BITS-1:0] post_seg;
        logic [ROW_BITS-1:0] post_row;
        logic [COL_BITS-1:0] post_col;
        logic [DATA_W-1:0]   post_data;
        logic                ref_pend;
        logic                ref_gnt;
        logic [ROW_BITS-1:0] ref_row;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [SEG_BITS-1:0] req_seg;
    logic [ROW_BITS-1:0] req_row;
    logic [COL_BITS-1:0] req_col;
    logic [NSEG-1:0]     hit_vec;
    logic [DATA_W-1:0]   seg_rd [NSEG];
    logic [COL_BITS-1:0] seg_col;
    logic [LINE_W-1:0]   arr_line;
    logic [LINE_W-1:0]   load_line;
    logic                accept, wr_go, rd_hit, miss_start, ref_any, ref_grant;

    assign req_seg = req_addr[ADDR_W-1 -: SEG_BITS];
    assign req_row = req_addr[COL_BITS +: ROW_BITS];
    assign req_col = req_addr[COL_BITS-1:0];

    assign ready      = (ctl_q.state == ST_READY);
    assign accept     = req_valid && ready;
    assign wr_go      = accept && req_write;
    assign rd_hit     = accept && !req_write && hit_vec[req_seg];
    assign miss_start = accept && !req_write && !hit_vec[req_seg];
    assign seg_col    = ready ? req_col : ctl_q.pend_col;
    assign ref_any    = ctl_q.ref_pend || refresh_req;
    assign ref_grant  = ref_any && ready && !miss_start;

    rrc_dram_array #(
        .DATA_W(DATA_W), .SEG_BITS(SEG_BITS), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)
    ) u_array (
        .clk     (clk),
        .wr_en   (ctl_q.post_valid),
        .wr_seg  (ctl_q.post_seg),
        .wr_row  (ctl_q.post_row),
        .wr_col  (ctl_q.post_col),
        .wr_data (ctl_q.post_data),
        .rd_seg  (req_seg),
        .rd_row  (req_row),
        .rd_line (arr_line)
    );

    // A reload in the cycle after a write sees the posted word before it is committed.
    always_comb begin
        load_line = arr_line;
        if (ctl_q.post_valid && ctl_q.post_seg == req_seg && ctl_q.post_row == req_row) begin
            load_line[ctl_q.post_col*DATA_W +: DATA_W] = ctl_q.post_data;
        end
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        rrc_seg_cache #(
            .DATA_W(DATA_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)
        ) u_seg (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_en    (miss_start && (req_seg == SEG_BITS'(s))),
            .load_row   (req_row),
            .load_line  (load_line),
            .wr_en      (wr_go && (req_seg == SEG_BITS'(s))),
            .wr_col     (req_col),
            .wr_data    (req_wdata),
            .lookup_row (req_row),
            .hit        (hit_vec[s]),
            .rd_col     (seg_col),
            .rd_data    (seg_rd[s])
        );
    end

    always_comb begin
        ctl_d            = ctl_q;
        ctl_d.rd_valid   = 1'b0;
        ctl_d.ref_gnt    = ref_grant;
        ctl_d.ref_pend   = ref_any && !ref_grant;
        ctl_d.post_valid = wr_go;
        if (wr_go) begin
            ctl_d.post_seg  = req_seg;
            ctl_d.post_row  = req_row;
            ctl_d.post_col  = req_col;
            ctl_d.post_data = req_wdata;
        end
        if (ref_grant) begin
            ctl_d.ref_row = ctl_q.ref_row + 1'b1;
        end
        if (rd_hit) begin
            ctl_d.rd_valid = 1'b1;
            ctl_d.rd_data  = seg_rd[req_seg];
            ctl_d.hit_n    = 1'b0;
        end
        if (miss_start) begin
            ctl_d.state    = ST_RELOAD;
            ctl_d.cnt      = CNT_W'(MISS_LAT - 1);
            ctl_d.pend_col = req_col;
            ctl_d.pend_seg = req_seg;
        end
        if (ctl_q.state == ST_RELOAD) begin
            if (ctl_q.cnt == '0) begin
                ctl_d.state    = ST_READY;
                ctl_d.rd_valid = 1'b1;
                ctl_d.rd_data  = seg_rd[ctl_q.pend_seg];
                ctl_d.hit_n    = 1'b1;
            end else begin
                ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_READY;
            ctl_q.hit_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_valid    = ctl_q.rd_valid;
    assign rd_data     = ctl_q.rd_data;
    assign hit_n       = ctl_q.hit_n;
    assign refresh_gnt = ctl_q.ref_gnt;
    assign refresh_row = ctl_q.ref_row;

    // R3
    hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !hit_n) |-> $past(ready));

    // R4
    miss_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && hit_n) |-> !$past(ready));

    // R10
    refresh_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_gnt |-> $past(ready));

    // R9
    refresh_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_gnt |-> (refresh_row == ROW_BITS'($past(refresh_row) + 1'b1)));
endmodule

// File: tb/rrc_top_bench.sv
module rrc_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W   = 8;
    localparam int SEG_BITS = 2;
    localparam int ROW_BITS = 3;
    localparam int COL_BITS = 2;
    localparam int MISS_LAT = 2;
    localparam int NSEG  = 1 << SEG_BITS;
    localparam int ROWS  = 1 << ROW_BITS;
    localparam int COLS  = 1 << COL_BITS;
    localparam int WORDS = NSEG * ROWS * COLS;
    localparam int AW    = SEG_BITS + ROW_BITS + COL_BITS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, refresh_req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic ready, rd_valid, hit_n, refresh_gnt;
    logic [DATA_W-1:0] rd_data;
    logic [ROW_BITS-1:0] refresh_row;

    int tests = 0, fails = 0, cycles = 0;

    rrc_top #(.DATA_W(DATA_W), .SEG_BITS(SEG_BITS), .ROW_BITS(ROW_BITS),
              .COL_BITS(COL_BITS), .MISS_LAT(MISS_LAT)) u_rrc_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .hit_n(hit_n),
        .refresh_req(refresh_req), .refresh_gnt(refresh_gnt), .refresh_row(refresh_row)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    int mem [WORDS];
    bit cvalid [NSEG];
    int ctag [NSEG];
    int cline [NSEG][COLS];
    bit m_busy;
    int m_rem, m_pcol, m_pseg, m_rrow;
    bit m_pend, e_rv, e_hn, e_gnt;
    int e_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSEG; s++) cvalid[s] = 1'b0;
            m_busy = 0; m_pend = 0; e_rv = 0; e_hn = 1; e_gnt = 0; m_rrow = 0;
        end else begin
            bit rdy, acc, hit, miss, any;
            int a, s, r, c;
            rdy = !m_busy;
            acc = req_valid && rdy;
            a = int'(req_addr);
            s = a / (ROWS * COLS);
            r = (a / COLS) % ROWS;
            c = a % COLS;
            hit = cvalid[s] && ctag[s] == r;
            miss = acc && !req_write && !hit;
            e_rv = 0;
            if (m_busy) begin
                m_rem--;
                if (m_rem == 0) begin
                    m_busy = 0; e_rv = 1; e_hn = 1; e_rd = cline[m_pseg][m_pcol];
                end
            end
            if (acc && req_write) begin
                mem[a] = int'(req_wdata);
                if (hit) cline[s][c] = int'(req_wdata);
            end
            if (acc && !req_write && hit) begin
                e_rv = 1; e_hn = 0; e_rd = cline[s][c];
            end
            if (miss) begin
                cvalid[s] = 1; ctag[s] = r;
                for (int k = 0; k < COLS; k++) cline[s][k] = mem[s*ROWS*COLS + r*COLS + k];
                m_busy = 1; m_rem = MISS_LAT; m_pcol = c; m_pseg = s;
            end
            any = m_pend || refresh_req;
            e_gnt = any && rdy && !miss;
            m_pend = any && !e_gnt;
            if (e_gnt) m_rrow = (m_rrow + 1) % ROWS;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(ready == !m_busy, "R4 ready", int'(ready), int'(!m_busy));
            check(rd_valid == e_rv, "R3 rd_valid", int'(rd_valid), int'(e_rv));
            if (e_rv) check(int'(rd_data) == e_rd, "R6 rd_data", int'(rd_data), e_rd);
            check(hit_n == e_hn, "R4 hit_n", int'(hit_n), int'(e_hn));
            check(refresh_gnt == e_gnt, "R10 refresh_gnt", int'(refresh_gnt), int'(e_gnt));
            check(int'(refresh_row) == m_rrow, "R9 refresh_row", int'(refresh_row), m_rrow);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic int addr_of(int s, int r, int c);
        return s*ROWS*COLS + r*COLS + c;
    endfunction

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    task automatic do_write(input int a, input int d);
        wait_ready();
        req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = DATA_W'(d);
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic do_read(input int a, output int d, output bit hn, output int lat);
        wait_ready();
        req_valid = 1; req_write = 0; req_addr = AW'(a);
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        while (!rd_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        d = int'(rd_data); hn = hit_n;
    endtask

    initial begin
        int d, lat;
        bit hn;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ready == 1, "R1 ready", int'(ready), 1);
        check(rd_valid == 0, "R1 rd_valid", int'(rd_valid), 0);
        check(hit_n == 1, "R1 hit_n", int'(hit_n), 1);
        check(refresh_gnt == 0, "R1 refresh_gnt", int'(refresh_gnt), 0);
        rst_n = 1;
        @(negedge clk);
        for (int a = 0; a < WORDS; a++) do_write(a, (a*37 + 5) & 255);

        // R1, R4: first read of segment 0 misses
        do_read(addr_of(0,1,2), d, hn, lat);
        check(hn == 1, "R1 first read miss", int'(hn), 1);
        check(lat == MISS_LAT + 1, "R4 miss latency", lat, MISS_LAT + 1);
        check(d == ((addr_of(0,1,2)*37+5)&255), "R4 miss data", d, (addr_of(0,1,2)*37+5)&255);
        // R5 back-to-back hits in any column order
        for (int c = COLS-1; c >= 0; c--) begin
            do_read(addr_of(0,1,c), d, hn, lat);
            check(hn == 0 && lat == 1, "R5 page hit", int'(hn), 0);
        end
        // R2 independent segments
        for (int s = 1; s < NSEG; s++) do_read(addr_of(s, s+2, 0), d, hn, lat);
        for (int s = 0; s < NSEG; s++) begin
            do_read(addr_of(s, (s == 0) ? 1 : s+2, 3), d, hn, lat);
            check(hn == 0, "R2 segment kept", int'(hn), 0);
        end
        // R7 write hit updates row register
        do_write(addr_of(0,1,2), 8'hA5);
        do_read(addr_of(0,1,2), d, hn, lat);
        check(hn == 0 && d == 8'hA5, "R7 coherent hit", d, 8'hA5);
        // R8 write miss leaves cached row alone; R6 reload right after write
        do_write(addr_of(0,5,0), 8'h3C);
        do_read(addr_of(0,1,0), d, hn, lat);
        check(hn == 0 && d == ((addr_of(0,1,0)*37+5)&255), "R8 write miss", d, (addr_of(0,1,0)*37+5)&255);
        do_write(addr_of(1,6,1), 8'h77);
        do_read(addr_of(1,6,1), d, hn, lat);
        check(hn == 1 && d == 8'h77, "R6 posted forward", d, 8'h77);
        // R9 refresh while idle
        refresh_req = 1; @(negedge clk); refresh_req = 0;
        check(refresh_gnt == 1, "R9 grant pulse", int'(refresh_gnt), 1);
        @(negedge clk);
        check(refresh_gnt == 0, "R9 single pulse", int'(refresh_gnt), 0);
        // R10 refresh request in the cycle a miss starts waits
        req_valid = 1; req_write = 0; req_addr = AW'(addr_of(2,7,1)); refresh_req = 1;
        @(negedge clk);
        req_valid = 0; refresh_req = 0;
        check(refresh_gnt == 0, "R10 held during reload", int'(refresh_gnt), 0);
        // R12 write during reload is dropped
        req_valid = 1; req_write = 1; req_addr = AW'(addr_of(2,7,1)); req_wdata = 8'hEE;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        wait_ready();
        @(negedge clk);
        check(refresh_gnt == 1, "R10 granted after reload", int'(refresh_gnt), 1);
        // R11, R12 row register unchanged by refresh and by the dropped write
        do_read(addr_of(2,7,1), d, hn, lat);
        check(hn == 0 && d == ((addr_of(2,7,1)*37+5)&255), "R11 R12 data kept", d, (addr_of(2,7,1)*37+5)&255);

        // Random traffic compared against the model every cycle
        for (int i = 0; i < 3000; i++) begin
            req_valid = 1'($urandom_range(0, 1));
            req_write = ($urandom_range(0, 3) == 0);
            req_addr = AW'($urandom_range(0, 5) < 4 ? addr_of($urandom_range(0,NSEG-1), $urandom_range(0,1), $urandom_range(0,COLS-1))
                                                    : $urandom_range(0, WORDS-1));
            req_wdata = DATA_W'($urandom);
            refresh_req = ($urandom_range(0, 7) == 0);
            @(negedge clk);
        end
        req_valid = 0; refresh_req = 0;
        repeat (6) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule